// File: doc/BRIEF.md
# Multi-Domain Reset Controller

This block turns a set of reset causes into three separately routed reset outputs and a shaped pulse on an open-drain external reset pin. The causes are supply fault flags from analog detectors (core power-on, core brownout, I/O power-on, backup-supply monitor), wake-up, watchdog and reinforced-watchdog requests, a software reset command, and a push-button on the external pin. A fault on the I/O supply resets only the I/O ring. A core brownout resets only the processor core. Every other cause resets the whole chip outside the backup domain and drives the pin low.

The block runs on the slow clock of the always-powered backup domain. Its synchronous, active-high `rst` input is the backup-domain power-on. That input is the only thing that clears the configuration register (detector enables and pulse length) and the last-reset cause code. All other resets leave both untouched, so software can read after reboot why the chip restarted.

Every sequence holds its resets for 2^(N+1) slow-clock cycles, where N is a 4-bit configuration field. A supply fault that is still present keeps reloading that count, so the hold time is measured from the moment the fault clears.

Top module: `rstctl_top`

## Requirements
- R1: While `rst` is high and after it falls, `cause_o` reads 0 (general). The brownout and backup-monitor enables read as 1 and N as PLEN_DEF (2). A full sequence runs: it stays asserted for 2^(N+1) cycles counted from the last cycle with `rst` high.
- R2: While `core_por_flt_i` is present, `sys_rst_o`, `core_rst_o`, `io_rst_o` and `nrst_oe_o` are held high. After the fault clears they stay high for 2^(N+1) more cycles, plus the two-cycle input synchronizer. `cause_o` becomes 0.
- R3: When the brownout enable is set, `core_bod_flt_i` asserts only `core_rst_o`, with the same hold rule as R2. `sys_rst_o`, `io_rst_o` and `nrst_oe_o` stay low, and `cause_o` becomes 0. When the enable is clear, the input has no effect.
- R4: `io_por_flt_i` drives `io_rst_o` two cycles later, for as long as it is present. It has no effect on `core_rst_o`, `sys_rst_o`, `nrst_oe_o` or `cause_o`.
- R5: When the backup-monitor enable is set, `bkup_mon_flt_i` acts like the core power-on fault of R2. When the enable is clear, the input has no effect.
- R6: Cause codes on `cause_o`: 0 general, 1 wake-up, 2 software, 3 user (pin), 4 watchdog, 5 reinforced watchdog. A wake-up, software, watchdog, reinforced-watchdog or user reset starts a full sequence (all three resets and the pin).
- R7: When causes coincide, one source wins, in this order from highest: power-on fault, brownout, reinforced watchdog, watchdog, user, software, wake-up.
- R8: The pin input passes through two synchronizer flops and must then read low for 3 consecutive cycles. Only then is a user reset taken. A low lasting 2 cycles or less is ignored. The block's own drive of the pin never counts as a press.
- R9: A full sequence holds `nrst_oe_o` and the resets for exactly 2^(N+1) cycles, for every N written through `cfg_plen_i`.
- R10: A software command (`cmd_wr_i` and `cmd_rst_i` both high) is ignored while a sequence is in progress. It neither extends the sequence nor changes `cause_o`.
- R11: Configuration written through `cfg_wr_i` survives every reset sequence. Only `rst` restores the defaults of R1.
- R12: Throughout a full sequence, `sys_rst_o`, `core_rst_o`, `io_rst_o` and `nrst_oe_o` are all high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow backup-domain clock |
| rst | input | 1 | Backup-domain power-on, synchronous, active high |
| core_por_flt_i | input | 1 | Core supply power-on fault (asynchronous) |
| core_bod_flt_i | input | 1 | Core supply brownout (asynchronous) |
| io_por_flt_i | input | 1 | I/O supply power-on fault (asynchronous) |
| bkup_mon_flt_i | input | 1 | Backup supply monitor fault (asynchronous) |
| wake_req_i | input | 1 | Wake-up reset request |
| wdog_rst_i | input | 1 | Watchdog reset request |
| rwdog_rst_i | input | 1 | Reinforced-watchdog reset request |
| nrst_pin_i | input | 1 | Level read back from the external reset pin, low active |
| nrst_oe_o | output | 1 | Drives the external pin low when high |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_bod_en_i | input | 1 | Brownout enable to write |
| cfg_bkmon_en_i | input | 1 | Backup-monitor enable to write |
| cfg_plen_i | input | 4 | Pulse-length exponent N to write |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_rst_i | input | 1 | Software reset request bit of the command |
| sys_rst_o | output | 1 | Whole-chip reset (backup domain excluded) |
| core_rst_o | output | 1 | Processor core reset |
| io_rst_o | output | 1 | I/O ring reset |
| cause_o | output | 3 | Cause of the last reset |

## Verification
Pulse length is swept over N from 0 to 11 using software resets. The measured width must match 2^(N+1) exactly, which exposes any off-by-one in the counter or the shift.

Each source is fired on its own, with a different cause left over from the previous run. This separates a cause that was written from one that was merely retained. It also shows which of the three resets and the pin each source reaches.

Pin presses of 1 to 5 cycles locate the debounce threshold. Coincident pairs of sources fix the priority order. Software commands issued in the middle of a sequence, and faults applied while their enable is clear, show that those inputs have no effect.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int PLEN_W = 4;
  localparam int CNT_W  = (1 << PLEN_W) + 1;

  typedef enum logic [2:0] {
    CAUSE_GENERAL = 3'd0,
    CAUSE_WAKE    = 3'd1,
    CAUSE_SOFT    = 3'd2,
    CAUSE_USER    = 3'd3,
    CAUSE_WDOG    = 3'd4,
    CAUSE_RWDOG   = 3'd5
  } cause_e;

  typedef struct packed {
    logic              bod_en;
    logic              bkmon_en;
    logic [PLEN_W-1:0] plen;
  } cfg_t;

  // bit positions inside the synchronized source vector
  localparam int SRC_CPOR  = 0;
  localparam int SRC_BOD   = 1;
  localparam int SRC_IOPOR = 2;
  localparam int SRC_BKMON = 3;
  localparam int SRC_WAKE  = 4;
  localparam int SRC_WDOG  = 5;
  localparam int SRC_RWDOG = 6;
  localparam int SRC_N     = 7;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) stg <= d_i;
  end else begin : g_chain
    always_ff @(posedge clk) stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DB_LEN      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic hold_i,
  output logic press_o
);
  logic              pin_s;
  logic [DB_LEN-1:0] hist;
  logic              level;

  rstctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .d_i(pin_i), .q_o(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= '1;
      level <= 1'b1;
    end else if (hold_i) begin
      hist  <= '0;
      level <= 1'b0;
    end else begin
      hist <= {hist[DB_LEN-2:0], pin_s};
      if (hist == '0)      level <= 1'b0;
      else if (&hist)      level <= 1'b1;
    end
  end

  assign press_o = level && (hist == '0) && !hold_i;
endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
  import rstctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             full_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic             busy_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b1;
      full_o <= 1'b1;
      cnt    <= len_m1_i;
    end else if (start_i) begin
      busy_o <= 1'b1;
      full_o <= full_i | (busy_o & full_o);
      cnt    <= len_m1_i;
    end else if (busy_o) begin
      if (cnt == '0) begin
        busy_o <= 1'b0;
        full_o <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int PLEN_DEF    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DB_LEN      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_por_flt_i,
  input  logic              core_bod_flt_i,
  input  logic              io_por_flt_i,
  input  logic              bkup_mon_flt_i,
  input  logic              wake_req_i,
  input  logic              wdog_rst_i,
  input  logic              rwdog_rst_i,
  input  logic              nrst_pin_i,
  output logic              nrst_oe_o,
  input  logic              cfg_wr_i,
  input  logic              cfg_bod_en_i,
  input  logic              cfg_bkmon_en_i,
  input  logic [PLEN_W-1:0] cfg_plen_i,
  input  logic              cmd_wr_i,
  input  logic              cmd_rst_i,
  output logic              sys_rst_o,
  output logic              core_rst_o,
  output logic              io_rst_o,
  output logic [2:0]        cause_o
);
  logic [SRC_N-1:0] src_raw, src_s;
  cfg_t             cfg_q;
  cause_e           cause_q, cause_n;
  logic             busy, full, start, start_full, press;
  logic             gen_flt, bod_flt, sw_req;
  logic [PLEN_W:0]  shamt;
  logic [CNT_W-1:0] len_m1;

  assign src_raw = {rwdog_rst_i, wdog_rst_i, wake_req_i, bkup_mon_flt_i,
                    io_por_flt_i, core_bod_flt_i, core_por_flt_i};

  rstctl_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_src_sync (
    .clk(clk), .d_i(src_raw), .q_o(src_s)
  );

  rstctl_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .DB_LEN(DB_LEN)) u_pin (
    .clk(clk), .rst(rst), .pin_i(nrst_pin_i), .hold_i(sys_rst_o), .press_o(press)
  );

  // configuration lives in the backup domain: only rst clears it
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.bod_en   <= 1'b1;
      cfg_q.bkmon_en <= 1'b1;
      cfg_q.plen     <= PLEN_W'(PLEN_DEF);
    end else if (cfg_wr_i) begin
      cfg_q.bod_en   <= cfg_bod_en_i;
      cfg_q.bkmon_en <= cfg_bkmon_en_i;
      cfg_q.plen     <= cfg_plen_i;
    end
  end

  assign shamt  = {1'b0, cfg_q.plen} + 1'b1;
  assign len_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);

  assign gen_flt = src_s[SRC_CPOR] | (cfg_q.bkmon_en & src_s[SRC_BKMON]);
  assign bod_flt = cfg_q.bod_en & src_s[SRC_BOD];
  assign sw_req  = cmd_wr_i & cmd_rst_i;

  // source arbitration; supply faults also re-arm a running sequence
  always_comb begin
    start      = 1'b1;
    start_full = 1'b1;
    cause_n    = cause_q;
    if (gen_flt) begin
      cause_n = CAUSE_GENERAL;
    end else if (bod_flt) begin
      start_full = 1'b0;
      cause_n    = CAUSE_GENERAL;
    end else if (busy) begin
      start = 1'b0;
    end else if (src_s[SRC_RWDOG]) begin
      cause_n = CAUSE_RWDOG;
    end else if (src_s[SRC_WDOG]) begin
      cause_n = CAUSE_WDOG;
    end else if (press) begin
      cause_n = CAUSE_USER;
    end else if (sw_req) begin
      cause_n = CAUSE_SOFT;
    end else if (src_s[SRC_WAKE]) begin
      cause_n = CAUSE_WAKE;
    end else begin
      start = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        cause_q <= CAUSE_GENERAL;
    else if (start) cause_q <= cause_n;
  end

  rstctl_seq u_seq (
    .clk(clk), .rst(rst), .start_i(start), .full_i(start_full),
    .len_m1_i(len_m1), .busy_o(busy), .full_o(full)
  );

  assign core_rst_o = busy;
  assign sys_rst_o  = busy & full;
  assign nrst_oe_o  = sys_rst_o;
  assign io_rst_o   = sys_rst_o | src_s[SRC_IOPOR];
  assign cause_o    = cause_q;
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
  import rstctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       core_por_flt_i,
  input logic       io_por_flt_i,
  input logic       cmd_wr_i,
  input logic       cmd_rst_i,
  input logic       sys_rst_o,
  input logic       core_rst_o,
  input logic       io_rst_o,
  input logic [2:0] cause_o
);
  AST_RST_GENERAL: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cause_o == CAUSE_GENERAL) && sys_rst_o); // R1
  AST_CPOR_FULL: assert property (@(posedge clk) disable iff (rst)
    $past(core_por_flt_i, SYNC_STAGES + 1) |-> sys_rst_o); // R2
  AST_IO_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(io_por_flt_i, SYNC_STAGES) |-> io_rst_o); // R4
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cause_o <= 3'd5); // R6
  AST_SW_IGNORED: assert property (@(posedge clk) disable iff (rst)
    core_rst_o && cmd_wr_i && cmd_rst_i && (cause_o != CAUSE_SOFT)
    |=> cause_o != CAUSE_SOFT); // R10
endmodule

bind rstctl_top rstctl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .core_por_flt_i(core_por_flt_i),
  .io_por_flt_i(io_por_flt_i), .cmd_wr_i(cmd_wr_i), .cmd_rst_i(cmd_rst_i),
  .sys_rst_o(sys_rst_o), .core_rst_o(core_rst_o), .io_rst_o(io_rst_o),
  .cause_o(cause_o)
);

// File: tb/tb_rstctl_top.sv
`timescale 1ns/1ps
module tb_rstctl_top;
  localparam int C_GEN = 0, C_WAKE = 1, C_SOFT = 2, C_USER = 3, C_WDOG = 4, C_RWDOG = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_por = 0, core_bod = 0, io_por = 0, bkmon = 0;
  logic wake = 0, wdog = 0, rwdog = 0, btn = 0;
  logic cfg_wr = 0, cfg_bod = 1, cfg_bkm = 1;
  logic [3:0] cfg_plen = 4'd2;
  logic cmd_wr = 0, cmd_rst = 0;
  logic nrst_oe, sys_rst, core_rst, io_rst;
  logic [2:0] cause;
  logic pin;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign pin = !(nrst_oe | btn);

  rstctl_top dut (
    .clk(clk), .rst(rst), .core_por_flt_i(core_por), .core_bod_flt_i(core_bod),
    .io_por_flt_i(io_por), .bkup_mon_flt_i(bkmon), .wake_req_i(wake),
    .wdog_rst_i(wdog), .rwdog_rst_i(rwdog), .nrst_pin_i(pin), .nrst_oe_o(nrst_oe),
    .cfg_wr_i(cfg_wr), .cfg_bod_en_i(cfg_bod), .cfg_bkmon_en_i(cfg_bkm),
    .cfg_plen_i(cfg_plen), .cmd_wr_i(cmd_wr), .cmd_rst_i(cmd_rst),
    .sys_rst_o(sys_rst), .core_rst_o(core_rst), .io_rst_o(io_rst), .cause_o(cause)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(int n, bit bod, bit bkm);
    cfg_plen = 4'(n); cfg_bod = bod; cfg_bkm = bkm; cfg_wr = 1;
    tick(1); cfg_wr = 0;
  endtask

  task automatic sw_cmd();
    cmd_wr = 1; cmd_rst = 1; tick(1); cmd_wr = 0; cmd_rst = 0;
  endtask

  // counts cycles of sys_rst high from now; shape flags any domain not covered
  task automatic measure_full(output int w, output int shape_ok);
    w = 0; shape_ok = 1;
    while (sys_rst && w < 70000) begin
      if (!core_rst || !io_rst || !nrst_oe) shape_ok = 0;
      w++; tick(1);
    end
  endtask

  task automatic wait_rise(output int seen);
    seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      if (core_rst) seen = 1; else tick(1);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int w, ok, seen, bad;
    tick(4);
    check("R1 sys during rst", sys_rst, 1);
    rst = 0;
    measure_full(w, ok);
    check("R1 power-up width", w, 8);
    check("R1 cause general", cause, C_GEN);
    check("R12 power-up shape", ok, 1);
    tick(10);

    // R9 pulse length sweep, software resets
    for (int n = 0; n < 12; n++) begin
      cfg_write(n, 1, 1);
      sw_cmd();
      measure_full(w, ok);
      check($sformatf("R9 width n=%0d", n), w, 1 << (n + 1));
      check("R6 soft code", cause, C_SOFT);
      check("R12 shape", ok, 1);
      tick(10);
    end

    cfg_write(3, 1, 1);
    // R10: software command mid-sequence
    sw_cmd();
    w = 0;
    while (sys_rst && w < 1000) begin
      cmd_wr = (w == 5); cmd_rst = (w == 5);
      w++; tick(1);
    end
    cmd_wr = 0; cmd_rst = 0;
    check("R10 no extension", w, 16);
    tick(10);
    wdog = 1; tick(1); wdog = 0;
    wait_rise(seen);
    w = 0;
    while (sys_rst && w < 1000) begin
      cmd_wr = (w == 3); cmd_rst = (w == 3);
      w++; tick(1);
    end
    cmd_wr = 0; cmd_rst = 0;
    check("R10 width under wdog", w, 16);
    check("R10 cause kept wdog (R6)", cause, C_WDOG);
    tick(10);

    // R6 remaining codes
    wake = 1; tick(1); wake = 0;
    wait_rise(seen);
    check("R6 wake full reset", sys_rst, 1);
    measure_full(w, ok);
    check("R6 wake code", cause, C_WAKE);
    tick(10);
    rwdog = 1; tick(1); rwdog = 0;
    wait_rise(seen);
    measure_full(w, ok);
    check("R6 rwdog code", cause, C_RWDOG);
    check("R6 rwdog width", w, 16);
    tick(10);

    // R8 debounce threshold sweep
    for (int l = 1; l <= 5; l++) begin
      btn = 1; tick(l); btn = 0;
      wait_rise(seen);
      check($sformatf("R8 press len=%0d", l), seen, (l >= 3) ? 1 : 0);
      if (seen) begin
        measure_full(w, ok);
        check("R8 user code (R6)", cause, C_USER);
      end
      tick(12);
    end

    // R7 priority
    wdog = 1; rwdog = 1; tick(1); wdog = 0; rwdog = 0;
    wait_rise(seen); measure_full(w, ok);
    check("R7 rwdog over wdog", cause, C_RWDOG);
    tick(10);
    wake = 1; wdog = 1; tick(1); wake = 0; wdog = 0;
    wait_rise(seen); measure_full(w, ok);
    check("R7 wdog over wake", cause, C_WDOG);
    tick(10);
    core_por = 1; rwdog = 1; tick(1); core_por = 0; rwdog = 0;
    wait_rise(seen); measure_full(w, ok);
    check("R7 por over rwdog", cause, C_GEN);
    tick(10);

    // R2 core power-on fault held
    sw_cmd(); measure_full(w, ok); tick(10);
    core_por = 1; tick(20);
    check("R2 sys held", sys_rst, 1);
    core_por = 0;
    measure_full(w, ok);
    check("R2 hold after release", w, 18);
    check("R2 cause general", cause, C_GEN);
    check("R12 por shape", ok, 1);
    tick(10);

    // R5 backup monitor
    sw_cmd(); measure_full(w, ok); tick(10);
    bkmon = 1; tick(6); bkmon = 0;
    measure_full(w, ok);
    check("R5 bkmon width", w, 18);
    check("R5 bkmon cause", cause, C_GEN);
    tick(10);
    cfg_write(3, 1, 0);
    sw_cmd(); measure_full(w, ok); tick(10);
    bad = 0;
    bkmon = 1;
    for (int i = 0; i < 10; i++) begin tick(1); if (core_rst) bad = 1; end
    bkmon = 0; tick(5);
    check("R5 disabled no reset", bad, 0);
    check("R5 disabled cause kept", cause, C_SOFT);

    // R3 brownout
    cfg_write(3, 1, 1);
    sw_cmd(); measure_full(w, ok); tick(10);
    bad = 0; seen = 0;
    core_bod = 1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (core_rst) seen = 1;
      if (sys_rst || io_rst || nrst_oe) bad = 1;
    end
    core_bod = 0;
    w = 0;
    while (core_rst && w < 1000) begin
      if (sys_rst || io_rst || nrst_oe) bad = 1;
      w++; tick(1);
    end
    check("R3 core reset seen", seen, 1);
    check("R3 core only", bad, 0);
    check("R3 core hold", w, 18);
    check("R3 cause general", cause, C_GEN);
    tick(10);
    cfg_write(3, 0, 1);
    sw_cmd(); measure_full(w, ok); tick(10);
    bad = 0;
    core_bod = 1;
    for (int i = 0; i < 10; i++) begin tick(1); if (core_rst) bad = 1; end
    core_bod = 0; tick(5);
    check("R3 disabled no reset", bad, 0);
    check("R3 disabled cause kept", cause, C_SOFT);

    // R4 I/O supply fault
    bad = 0;
    io_por = 1; tick(3);
    check("R4 io reset", io_rst, 1);
    for (int i = 0; i < 10; i++) begin
      if (core_rst || sys_rst || nrst_oe) bad = 1;
      tick(1);
    end
    io_por = 0; tick(3);
    check("R4 io released", io_rst, 0);
    check("R4 core untouched", bad, 0);
    check("R4 cause kept", cause, C_SOFT);

    // R11 retention through reset sequences
    wdog = 1; tick(1); wdog = 0;
    wait_rise(seen); measure_full(w, ok);
    check("R11 plen kept", w, 16);
    tick(10);
    bad = 0;
    core_bod = 1;
    for (int i = 0; i < 8; i++) begin tick(1); if (core_rst) bad = 1; end
    core_bod = 0; tick(5);
    check("R11 bod disable kept", bad, 0);

    // R1 backup power-on restores defaults
    rst = 1; tick(3);
    check("R1 cause in rst", cause, C_GEN);
    rst = 0;
    measure_full(w, ok);
    check("R1 default width", w, 8);
    tick(10);
    sw_cmd(); measure_full(w, ok); tick(10);
    core_bod = 1; tick(6); core_bod = 0;
    check("R1 bod enabled again", core_rst, 1);
    check("R1 sys not hit by bod", sys_rst, 0);
    tick(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule